// File: doc/BRIEF.md
# Automatic Serial Burst Master with Activity-Paced Byte Gaps

This block is a serial master that moves a run of 8-bit bytes over a three-wire link: a clock it generates itself, a data output and a data input. A single start strobe launches the run. The block asks for each outgoing byte on a parallel port. It shifts the byte out most significant bit first while it shifts a byte in. It returns each received byte on a parallel port with a one-cycle valid pulse.

Between two bytes of a run, the serial clock rests high for an idle gap. The gap has two sources. The first is a floor that follows the current processor activity class: plain, multiply, divide, or external access with one wait state. The floor is the larger of two and a half serial periods and a class-dependent number of processor clock cycles. The second source is optional. When the enable bit of an interval register is set, the register's programmed length can raise the gap above the floor. The block only runs when internal-clock operation is selected. It raises a done pulse when the last byte completes, with no gap after it.

Top module: `ser_auto_xfer`

## Requirements
- R1: After reset, `sck_o` is high, and `so_o`, `busy_o`, `done_o`, `rx_valid_o` and `data_ack_o` are low.
- R2: A start is taken only when the block is idle, `int_clk_i` is 1 and `byte_cnt_i` is nonzero. In any other case the strobe is ignored, so `busy_o` stays low and `sck_o` stays high.
- R3: Each bit takes a low half of SCK_HALF clock cycles followed by a high half of SCK_HALF cycles. Bits leave MSB first, and `so_o` changes only in the cycle where `sck_o` falls.
- R4: `si_i` is sampled on the clock edge where `sck_o` rises, with the first sample landing in bit 7. When the final high half of a byte ends, `rx_valid_o` pulses for one cycle and the received byte is on `rx_data_o`.
- R5: `tx_data_i` is captured on the edge that starts a byte. `data_ack_o` is high for the following cycle, and during that cycle `sck_o` is low.
- R6: With `interval_i[7]`=0, the gap between the end of one byte's last high half and the next falling edge of `sck_o` is exactly max(5·SCK_HALF, N·CPU_DIV) cycles, with `sck_o` held high. N is 7, 13, 20 or 9 for `act_i` codes 00 (plain), 01 (multiply), 10 (divide) and 11 (external access, one wait).
- R7: With `interval_i[7]`=1, the gap is the larger of the R6 value and `interval_i[6:0]`·2·SCK_HALF cycles.
- R8: `act_i` and `interval_i` are read only on the edge that ends a byte. Changes at other times do not affect that gap.
- R9: At the end of the last byte, `done_o` pulses for one cycle, `busy_o` falls in that same cycle and no gap follows. While idle, `sck_o` is high.
- R10: A start strobe while `busy_o` is high is ignored, so the run delivers exactly `byte_cnt_i` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_clk_i | input | 1 | Internal serial clock operation selected |
| start_i | input | 1 | Start strobe for a run |
| byte_cnt_i | input | CNT_W | Number of bytes in the run |
| tx_data_i | input | DW | Next byte to send |
| data_ack_o | output | 1 | tx_data_i was captured on the previous edge |
| rx_data_o | output | DW | Last received byte |
| rx_valid_o | output | 1 | rx_data_o updated |
| act_i | input | 2 | Processor activity class |
| interval_i | input | 8 | Bit 7 enables the programmed gap; bits 6:0 give its length in serial periods |
| sck_o | output | 1 | Serial clock, idles high |
| so_o | output | 1 | Serial data out |
| si_i | input | 1 | Serial data in |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete pulse |

## Verification
The hardest condition to reach is a gap that depends on the activity class and interval register values present on the one edge that ends a byte. Values a few cycles earlier or later must not affect it. The stimulus reaches this in one run where a background driver changes `act_i` and `interval_i` every few cycles, so their values during the bit stream differ from those on the byte-end edge. The reference model reads both inputs on that edge only. A second start strobe arrives in the middle of the same run, and the bench confirms the byte count does not change.

// File: rtl/ser_auto_pkg.sv
`timescale 1ns/1ps
package ser_auto_pkg;

  typedef enum logic [1:0] {
    ACT_PLAIN = 2'b00,
    ACT_MUL   = 2'b01,
    ACT_DIV   = 2'b10,
    ACT_WAIT1 = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_GAP   = 2'b10
  } state_e;

  // processor cycles of the activity floor
  function automatic logic [4:0] act_cycles(input act_e a);
    case (a)
      ACT_MUL:   return 5'd13;
      ACT_DIV:   return 5'd20;
      ACT_WAIT1: return 5'd9;
      default:   return 5'd7;
    endcase
  endfunction

endpackage

// File: rtl/ser_gap_calc.sv
`timescale 1ns/1ps
module ser_gap_calc import ser_auto_pkg::*; #(
  parameter int SCK_HALF = 2,
  parameter int CPU_DIV  = 1,
  parameter int GAP_W    = 12
) (
  input  logic [1:0]       act_i,
  input  logic [7:0]       interval_i,
  output logic [GAP_W-1:0] gap_o
);
  localparam logic [GAP_W-1:0] MinGap  = GAP_W'(5 * SCK_HALF);
  localparam logic [GAP_W-1:0] PerSlot = GAP_W'(2 * SCK_HALF);
  localparam logic [GAP_W-1:0] CpuMul  = GAP_W'(CPU_DIV);

  logic [GAP_W-1:0] act_gap, floor_gap, prog_gap;

  always_comb begin
    act_gap   = GAP_W'(act_cycles(act_e'(act_i))) * CpuMul;
    floor_gap = (act_gap > MinGap) ? act_gap : MinGap;
    prog_gap  = GAP_W'(interval_i[6:0]) * PerSlot;
    gap_o     = (interval_i[7] && prog_gap > floor_gap) ? prog_gap : floor_gap;
  end
endmodule

// File: rtl/ser_byte_shifter.sv
`timescale 1ns/1ps
module ser_byte_shifter #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic          sample_i,
  input  logic [DW-1:0] tx_i,
  input  logic          si_i,
  output logic          so_o,
  output logic [DW-1:0] rx_o
);
  logic [DW-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)        tx_q <= tx_i;
      else if (shift_i)  tx_q <= {tx_q[DW-2:0], 1'b0};
      if (sample_i)      rx_q <= {rx_q[DW-2:0], si_i};
    end
  end

  assign so_o = tx_q[DW-1];
  assign rx_o = rx_q;
endmodule

// File: rtl/ser_auto_xfer.sv
`timescale 1ns/1ps
module ser_auto_xfer import ser_auto_pkg::*; #(
  parameter int SCK_HALF = 2,
  parameter int CPU_DIV  = 1,
  parameter int DW       = 8,
  parameter int CNT_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_clk_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic [DW-1:0]    tx_data_i,
  output logic             data_ack_o,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_valid_o,
  input  logic [1:0]       act_i,
  input  logic [7:0]       interval_i,
  output logic             sck_o,
  output logic             so_o,
  input  logic             si_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int HC_W    = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BIT_W   = $clog2(DW);
  localparam int GAP_MAX = 127 * 2 * SCK_HALF + 20 * CPU_DIV + 5 * SCK_HALF;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam logic [HC_W-1:0]  HalfLd  = HC_W'(SCK_HALF - 1);
  localparam logic [BIT_W-1:0] LastBit = BIT_W'(DW - 1);

  state_e           state_q;
  logic             sck_q, ack_q, valid_q, done_q;
  logic [HC_W-1:0]  hcnt_q;
  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] rem_q;
  logic [GAP_W-1:0] gcnt_q, gap_w;
  logic [DW-1:0]    rx_byte, rx_q;

  logic start_go, half_done, ld_byte, rise, fall, byte_end, last_byte;

  assign start_go  = (state_q == ST_IDLE) && start_i && int_clk_i && (byte_cnt_i != '0);
  assign half_done = (hcnt_q == '0);
  assign ld_byte   = start_go || (state_q == ST_GAP && gcnt_q == '0);
  assign rise      = (state_q == ST_SHIFT) && half_done && !sck_q;
  assign fall      = (state_q == ST_SHIFT) && half_done && sck_q && (bit_q != LastBit);
  assign byte_end  = (state_q == ST_SHIFT) && half_done && sck_q && (bit_q == LastBit);
  assign last_byte = (rem_q == CNT_W'(1));

  ser_gap_calc #(.SCK_HALF(SCK_HALF), .CPU_DIV(CPU_DIV), .GAP_W(GAP_W)) u_gap (
    .act_i      (act_i),
    .interval_i (interval_i),
    .gap_o      (gap_w)
  );

  ser_byte_shifter #(.DW(DW)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ld_byte),
    .shift_i  (fall),
    .sample_i (rise),
    .tx_i     (tx_data_i),
    .si_i     (si_i),
    .so_o     (so_o),
    .rx_o     (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b1;
      hcnt_q  <= '0;
      bit_q   <= '0;
      rem_q   <= '0;
      gcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_go) begin
          state_q <= ST_SHIFT;
          rem_q   <= byte_cnt_i;
        end
        ST_SHIFT: if (byte_end) begin
          if (last_byte) state_q <= ST_IDLE;
          else begin
            state_q <= ST_GAP;
            rem_q   <= rem_q - CNT_W'(1);
            gcnt_q  <= gap_w - GAP_W'(1);
          end
        end
        ST_GAP: begin
          if (gcnt_q == '0) state_q <= ST_SHIFT;
          else              gcnt_q  <= gcnt_q - GAP_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase

      if (ld_byte || fall)  sck_q <= 1'b0;
      else if (rise)        sck_q <= 1'b1;

      if (ld_byte || rise || fall)                hcnt_q <= HalfLd;
      else if (state_q == ST_SHIFT && !half_done) hcnt_q <= hcnt_q - HC_W'(1);

      if (ld_byte)   bit_q <= '0;
      else if (fall) bit_q <= bit_q + BIT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      ack_q   <= ld_byte;
      valid_q <= byte_end;
      done_q  <= byte_end && last_byte;
      if (byte_end) rx_q <= rx_byte;
    end
  end

  assign sck_o      = sck_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign data_ack_o = ack_q;
  assign rx_valid_o = valid_q;
  assign rx_data_o  = rx_q;
endmodule

// File: rtl/ser_auto_chk.sv
`timescale 1ns/1ps
module ser_auto_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic int_clk_i,
  input logic sck_o,
  input logic so_o,
  input logic busy_o,
  input logic done_o,
  input logic rx_valid_o,
  input logic data_ack_o
);
  // R3
  so_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(so_o) |-> $fell(sck_o));

  // R9
  idle_sck_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sck_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  no_start_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !int_clk_i) |=> !busy_o);

  // R5
  ack_low_sck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ack_o |-> !sck_o);

  // R4
  valid_high_sck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> sck_o);
endmodule

bind ser_auto_xfer ser_auto_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .int_clk_i  (int_clk_i),
  .sck_o      (sck_o),
  .so_o       (so_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rx_valid_o (rx_valid_o),
  .data_ack_o (data_ack_o)
);

// File: tb/tb_ser_auto_xfer.sv
`timescale 1ns/1ps
module tb_ser_auto_xfer;
  localparam int H  = 2;
  localparam int CD = 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       int_clk_i = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] byte_cnt_i = '0;
  logic [7:0] tx_data_i = '0;
  logic       data_ack_o;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic [1:0] act_i = '0;
  logic [7:0] interval_i = '0;
  logic       sck_o, so_o, busy_o, done_o;
  logic       si_i = 1'b0;

  ser_auto_xfer #(.SCK_HALF(H), .CPU_DIV(CD), .DW(8), .CNT_W(8)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input int a, input int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, a, e, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic exp_sck = 1, exp_so = 0, exp_busy = 0, exp_done = 0, exp_valid = 0, exp_ack = 0;
  logic [7:0] exp_rx = '0;
  int gq[$];
  string tagq[$];
  bit toggling = 0;

  function automatic int gap_of(input logic [1:0] a, input logic [7:0] iv);
    int n, f, p;
    case (a)
      2'b01: n = 13;
      2'b10: n = 20;
      2'b11: n = 9;
      default: n = 7;
    endcase
    f = (n * CD > 5 * H) ? n * CD : 5 * H;
    p = int'(iv[6:0]) * 2 * H;
    return (iv[7] && p > f) ? p : f;
  endfunction

  task automatic tick();
    @(posedge clk_i);
    exp_valid = 0; exp_done = 0; exp_ack = 0;
  endtask

  initial begin
    logic [7:0] data, rxv;
    int n, g;
    wait (rst_ni);
    forever begin
      tick();
      if (int_clk_i && start_i && byte_cnt_i != 0) begin
        n = int'(byte_cnt_i);
        exp_busy = 1;
        rxv = '0;
        for (int k = 0; k < n; k++) begin
          data = tx_data_i;
          exp_ack = 1;
          for (int bt = 7; bt >= 0; bt--) begin
            exp_sck = 0; exp_so = data[bt];
            repeat (H) tick();
            rxv = {rxv[6:0], si_i};
            exp_sck = 1;
            repeat (H) tick();
          end
          exp_valid = 1; exp_rx = rxv;
          if (k == n - 1) begin
            exp_done = 1; exp_busy = 0;
          end else begin
            g = gap_of(act_i, interval_i);
            gq.push_back(g);
            tagq.push_back(toggling ? "R8 gap" : (interval_i[7] ? "R7 gap" : "R6 gap"));
            repeat (g) tick();
          end
        end
      end
    end
  end

  // ---------------- per-cycle compare ----------------
  int rx_cnt = 0, done_cnt = 0;
  initial begin
    wait (rst_ni);
    forever begin
      @(negedge clk_i);
      chk(sck_o == exp_sck, "R3 sck", sck_o, exp_sck);
      chk(so_o == exp_so, "R3 so", so_o, exp_so);
      chk(busy_o == exp_busy, "R9 busy", busy_o, exp_busy);
      chk(done_o == exp_done, "R9 done", done_o, exp_done);
      chk(rx_valid_o == exp_valid, "R4 valid", rx_valid_o, exp_valid);
      chk(data_ack_o == exp_ack, "R5 ack", data_ack_o, exp_ack);
      if (rx_valid_o) begin
        rx_cnt++;
        chk(rx_data_o == exp_rx, "R4 rx_data", rx_data_o, exp_rx);
      end
      if (done_o) done_cnt++;
    end
  end

  // ---------------- gap measurement ----------------
  initial begin
    int c, e;
    string t;
    wait (rst_ni);
    forever begin
      @(negedge clk_i);
      if (rx_valid_o && busy_o) begin
        c = 0;
        while (!data_ack_o && c < 2000) begin
          @(negedge clk_i);
          c++;
        end
        if (gq.size() > 0) begin
          e = gq.pop_front(); t = tagq.pop_front();
        end else begin
          e = -1; t = "R6 gap";
        end
        chk(c == e, t, c, e);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] tx_buf[8];
  int tx_idx = 0;
  logic [7:0] lfsr = 8'hA5;

  always @(negedge clk_i) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    si_i <= lfsr[0];
    if (data_ack_o) begin
      tx_idx = tx_idx + 1;
      tx_data_i <= tx_buf[tx_idx % 8];
    end
  end

  int tog_cnt = 0;
  always @(negedge clk_i) begin
    if (toggling) begin
      tog_cnt++;
      if (tog_cnt % 3 == 0) begin
        act_i <= act_i + 2'd1;
        interval_i <= {interval_i[7] ^ 1'b1, 7'(tog_cnt % 9)};
      end
    end
  end

  task automatic pulse_start();
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic run_xfer(input int n, input logic [1:0] a, input logic [7:0] iv, input bit mid_start);
    int r0, d0, w;
    for (int i = 0; i < 8; i++) tx_buf[i] = 8'(8'h3C + i * 37);
    tx_idx = 0;
    tx_data_i = tx_buf[0];
    act_i = a; interval_i = iv;
    byte_cnt_i = 8'(n);
    int_clk_i = 1;
    r0 = rx_cnt; d0 = done_cnt;
    pulse_start();
    if (mid_start) begin
      repeat (40) @(negedge clk_i);
      byte_cnt_i = 8'd1;
      pulse_start();
    end
    w = 0;
    while (busy_o && w < 5000) begin
      @(negedge clk_i);
      w++;
    end
    repeat (3) @(negedge clk_i);
    chk(rx_cnt - r0 == n, "R10 byte count", rx_cnt - r0, n);
    chk(done_cnt - d0 == 1, "R9 done count", done_cnt - d0, 1);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk_i);
    chk(sck_o == 1 && so_o == 0, "R1 serial idle", {sck_o, so_o}, 2);
    chk(!busy_o && !done_o && !rx_valid_o && !data_ack_o, "R1 flags", busy_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2: external mode selected, start ignored
    int_clk_i = 0; byte_cnt_i = 8'd2;
    pulse_start();
    repeat (5) @(negedge clk_i);
    chk(!busy_o && sck_o, "R2 ext mode ignored", busy_o, 0);
    // R2: zero count ignored
    int_clk_i = 1; byte_cnt_i = 8'd0;
    pulse_start();
    repeat (5) @(negedge clk_i);
    chk(!busy_o && sck_o, "R2 zero count ignored", busy_o, 0);

    run_xfer(3, 2'b00, 8'h00, 0);  // R6 plain: 10
    run_xfer(2, 2'b01, 8'h00, 0);  // R6 multiply: 13
    run_xfer(2, 2'b10, 8'h00, 0);  // R6 divide: 20
    run_xfer(2, 2'b11, 8'h00, 0);  // R6 wait: 10
    run_xfer(2, 2'b10, 8'h07, 0);  // R6 enable off: 20
    run_xfer(3, 2'b10, 8'h87, 0);  // R7 programmed wins: 28
    run_xfer(2, 2'b01, 8'h81, 0);  // R7 activity wins: 13
    run_xfer(1, 2'b00, 8'h00, 0);  // R9 single byte, no gap
    toggling = 1;
    run_xfer(5, 2'b00, 8'h85, 1);  // R8 sampled at byte end, R10 mid start
    toggling = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule